// File: doc/BRIEF.md
# CPU Idle-Mode Clock and Wake Controller

This block manages the single low-power state of a small microcontroller core. When the CPU signals that it has executed an idle (WAIT) opcode, the controller removes the enable from the CPU core clock. It pulses a strobe that clears the interrupt mask bit in the condition codes. The peripheral clock enable stays on, so timers can still raise interrupts and the watchdog can still reset the chip. Registers, memory and I/O are untouched because only the core clock stops.

Any interrupt request seen while idle re-enables the core clock on the next edge. A periodic timer interrupt is the usual way to leave idle. A watchdog reset forces the run state at once, whatever the current mode. A request from the stop opcode is treated as a no-operation: no clock stops and the mask is left alone, so the watchdog is never frozen. Enable outputs stand in for real clock-gating cells.

Top module: `idle_wake_top`

## Requirements
- R1: After the asynchronous active-low reset, cpuClkEn=1, perClkEn=1, iBitClr=0 and modeWait=0.
- R2: An idle strobe (exWait=1) sampled at a clock edge while running, with wdtReset=0, makes cpuClkEn=0 and modeWait=1 from the next cycle.
- R3: iBitClr is high for exactly one cycle: the cycle that follows the edge where R2 enters idle. It is low at all other times.
- R4: perClkEn is 1 in every cycle and every mode.
- R5: A stop strobe (exStop=1) without exWait changes no output. The core clock stays enabled and iBitClr stays low.
- R6: In idle, any bit of irqReq high at a clock edge (with wdtReset=0) returns modeWait=0 and cpuClkEn=1 in the next cycle.
- R7: wdtReset high at a clock edge gives modeWait=0, cpuClkEn=1 and iBitClr=0 in the next cycle. This holds in either mode, and also when exWait is high at the same edge.
- R8: In idle, with no interrupt request and no watchdog reset, the block stays idle. exWait and exStop have no effect there.
- R9: An interrupt already pending when the idle strobe is sampled gates the core clock for exactly one cycle before the run state returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rstN | input | 1 | Asynchronous active-low reset |
| exWait | input | 1 | CPU has executed the idle opcode (one-cycle strobe) |
| exStop | input | 1 | CPU has executed the stop opcode (one-cycle strobe) |
| irqReq | input | NumIrq | Interrupt request lines from peripherals |
| wdtReset | input | 1 | Watchdog reset request |
| cpuClkEn | output | 1 | Enable for the CPU core clock |
| perClkEn | output | 1 | Enable for the peripheral clocks |
| iBitClr | output | 1 | One-cycle strobe to clear the interrupt mask bit |
| modeWait | output | 1 | Mode status: 1 while idle |

## Verification
The bench targets several corner cases:
- An interrupt that is already pending when idle is entered. A design that checked for the interrupt only before entry would never gate the clock, and one that missed it would stay gated too long.
- A watchdog reset arriving in the same cycle as an idle strobe. A design with the wrong priority would drop into idle with the watchdog ignored.
- Stop strobes, and idle strobes that arrive while already idle. These expose a design that stops the clock on stop, or that re-pulses the mask clear.
- Random mixes of strobes, interrupts and watchdog resets. These catch a mask-clear strobe that lasts longer than one cycle, and a peripheral enable that ever drops.

// File: rtl/idle_wake_pkg.sv
package idle_wake_pkg;

  typedef enum logic {
    MODE_RUN  = 1'b0,
    MODE_IDLE = 1'b1
  } modeT;

  typedef struct packed {
    logic enterIdle;
    logic leaveIdle;
    logic forceRun;
  } wakeStrbT;

endpackage

// File: rtl/idle_wake_ctrl.sv
module idle_wake_ctrl
  import idle_wake_pkg::*;
#(
  parameter int NumIrq = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              exWait,
  input  logic              exStop,
  input  logic [NumIrq-1:0] irqReq,
  input  logic              wdtReset,
  input  logic              modeWait,
  output wakeStrbT          strb
);

  localparam int ChainLen = NumIrq + 1;

  logic [ChainLen-1:0] anyChain;
  logic                irqAny;

  assign anyChain[0] = 1'b0;
  for (genvar g = 0; g < NumIrq; g++) begin : gIrqOr
    assign anyChain[g+1] = anyChain[g] | irqReq[g];
  end
  assign irqAny = anyChain[ChainLen-1];

  always_comb begin
    strb = '0;
    if (wdtReset) begin
      strb.forceRun = 1'b1;
    end else if (!modeWait) begin
      strb.enterIdle = exWait;
    end else begin
      strb.leaveIdle = irqAny;
    end
  end

  AST_STOP_NO_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (exStop && !exWait) |-> !strb.enterIdle); // R5

  AST_WAKE_ON_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (modeWait && !wdtReset && (irqReq != '0)) |-> strb.leaveIdle); // R6

endmodule

// File: rtl/idle_wake_regs.sv
module idle_wake_regs
  import idle_wake_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  wakeStrbT strb,
  output logic     cpuClkEn,
  output logic     perClkEn,
  output logic     iBitClr,
  output logic     modeWait
);

  modeT modeQ;
  logic clrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= MODE_RUN;
      clrQ  <= 1'b0;
    end else begin
      clrQ <= strb.enterIdle;
      if (strb.forceRun || strb.leaveIdle) begin
        modeQ <= MODE_RUN;
      end else if (strb.enterIdle) begin
        modeQ <= MODE_IDLE;
      end
    end
  end

  assign modeWait = (modeQ == MODE_IDLE);
  assign cpuClkEn = (modeQ == MODE_RUN);
  assign perClkEn = 1'b1;
  assign iBitClr  = clrQ;

  AST_ENTER_GATES: assert property (@(posedge clk) disable iff (!rstN)
    strb.enterIdle |=> (!cpuClkEn && modeWait)); // R2

  AST_CLR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    iBitClr |=> !iBitClr); // R3

  AST_FORCE_RUN: assert property (@(posedge clk) disable iff (!rstN)
    strb.forceRun |=> (cpuClkEn && !iBitClr)); // R7

endmodule

// File: rtl/idle_wake_top.sv
module idle_wake_top
  import idle_wake_pkg::*;
#(
  parameter int NumIrq = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              exWait,
  input  logic              exStop,
  input  logic [NumIrq-1:0] irqReq,
  input  logic              wdtReset,
  output logic              cpuClkEn,
  output logic              perClkEn,
  output logic              iBitClr,
  output logic              modeWait
);

  wakeStrbT strb;

  idle_wake_ctrl #(.NumIrq(NumIrq)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .exWait   (exWait),
    .exStop   (exStop),
    .irqReq   (irqReq),
    .wdtReset (wdtReset),
    .modeWait (modeWait),
    .strb     (strb)
  );

  idle_wake_regs uRegs (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .cpuClkEn (cpuClkEn),
    .perClkEn (perClkEn),
    .iBitClr  (iBitClr),
    .modeWait (modeWait)
  );

  AST_WDT_TO_RUN: assert property (@(posedge clk) disable iff (!rstN)
    wdtReset |=> (cpuClkEn && !modeWait)); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (modeWait && (irqReq == '0) && !wdtReset) |=> modeWait); // R8

  AST_STOP_NOP: assert property (@(posedge clk) disable iff (!rstN)
    (exStop && !exWait && cpuClkEn && !wdtReset) |=> (cpuClkEn && !iBitClr)); // R5

endmodule

// File: tb/tb_idle_wake_top.sv
module tb_idle_wake_top;

  localparam int NumIrq = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              exWait = 1'b0;
  logic              exStop = 1'b0;
  logic [NumIrq-1:0] irqReq = '0;
  logic              wdtReset = 1'b0;
  logic              cpuClkEn, perClkEn, iBitClr, modeWait;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic expIdle = 1'b0;
  logic expClr = 1'b0;

  always #4 clk = ~clk;

  idle_wake_top #(.NumIrq(NumIrq)) dut (
    .clk(clk), .rstN(rstN), .exWait(exWait), .exStop(exStop),
    .irqReq(irqReq), .wdtReset(wdtReset),
    .cpuClkEn(cpuClkEn), .perClkEn(perClkEn),
    .iBitClr(iBitClr), .modeWait(modeWait)
  );

  function automatic logic nextIdle(logic idle, logic w, logic [NumIrq-1:0] irq, logic wdt);
    if (wdt) return 1'b0;
    if (!idle) return w;
    return (irq == '0);
  endfunction

  function automatic logic nextClr(logic idle, logic w, logic wdt);
    return !wdt && !idle && w;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expIdle <= 1'b0;
      expClr  <= 1'b0;
    end else begin
      expIdle <= nextIdle(expIdle, exWait, irqReq, wdtReset);
      expClr  <= nextClr(expIdle, exWait, wdtReset);
    end
  end

  task automatic check(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkAll(string tag);
    check({tag, " cpuClkEn R2/R6/R7"}, cpuClkEn, !expIdle);
    check({tag, " modeWait R2/R8"}, modeWait, expIdle);
    check({tag, " iBitClr R3"}, iBitClr, expClr);
    check({tag, " perClkEn R4"}, perClkEn, 1'b1);
  endtask

  task automatic step(logic w, logic s, logic [NumIrq-1:0] irq, logic wdt);
    exWait = w; exStop = s; irqReq = irq; wdtReset = wdt;
    @(posedge clk);
    @(negedge clk);
    exWait = 1'b0; exStop = 1'b0; irqReq = '0; wdtReset = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd20240611));
    repeat (2) @(negedge clk);
    check("reset R1 cpuClkEn", cpuClkEn, 1'b1);
    check("reset R1 perClkEn", perClkEn, 1'b1);
    check("reset R1 iBitClr", iBitClr, 1'b0);
    check("reset R1 modeWait", modeWait, 1'b0);
    rstN = 1'b1;
    @(negedge clk);

    // R5: stop strobe alone
    step(1'b0, 1'b1, '0, 1'b0);
    check("stop R5 cpuClkEn", cpuClkEn, 1'b1);
    check("stop R5 iBitClr", iBitClr, 1'b0);
    check("stop R5 modeWait", modeWait, 1'b0);

    // R2, R3: enter idle
    step(1'b1, 1'b0, '0, 1'b0);
    check("enter R2 cpuClkEn", cpuClkEn, 1'b0);
    check("enter R3 iBitClr", iBitClr, 1'b1);
    // R8: strobes ignored in idle
    step(1'b1, 1'b1, '0, 1'b0);
    check("hold R8 modeWait", modeWait, 1'b1);
    check("hold R3 iBitClr low", iBitClr, 1'b0);
    for (int i = 0; i < 4; i++) begin
      step(1'b0, 1'b0, '0, 1'b0);
      check("hold R8 cpuClkEn", cpuClkEn, 1'b0);
    end
    // R6: wake on top interrupt line
    step(1'b0, 1'b0, 4'b1000, 1'b0);
    check("wake R6 cpuClkEn", cpuClkEn, 1'b1);
    check("wake R6 modeWait", modeWait, 1'b0);

    // R9: interrupt pending at entry
    exWait = 1'b1; irqReq = 4'b0010;
    @(posedge clk); @(negedge clk);
    exWait = 1'b0;
    check("pending R9 gated one cycle", cpuClkEn, 1'b0);
    @(posedge clk); @(negedge clk);
    irqReq = '0;
    check("pending R9 back to run", cpuClkEn, 1'b1);

    // R7: watchdog with simultaneous idle strobe
    step(1'b1, 1'b0, '0, 1'b1);
    check("wdt R7 beats wait cpuClkEn", cpuClkEn, 1'b1);
    check("wdt R7 iBitClr", iBitClr, 1'b0);
    // R7: watchdog from idle
    step(1'b1, 1'b0, '0, 1'b0);
    step(1'b0, 1'b0, '0, 1'b1);
    check("wdt R7 from idle", modeWait, 1'b0);
    checkAll("directed");

    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic w, s, d;
      logic [NumIrq-1:0] q;
      w = (($urandom % 6) == 0);
      s = (($urandom % 5) == 0);
      d = (($urandom % 40) == 0);
      q = (($urandom % 7) == 0) ? NumIrq'($urandom) : '0;
      step(w, s, q, d);
      checkAll("random");
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule